// File: doc/BRIEF.md
# Trace Idle Entry Sequencer

This block decides when a trace-capture unit may be treated as quiescent, so that its clock can be gated or its power domain switched off. Six request sources feed it: three configuration bits (power-down, programming, enable), a save/restore lock, a wait-for-interrupt idle request, and a pair of debug-enable inputs. If any of these asks for idle while trace is running, the block switches trace generation off. It then steps through a drain in a fixed order, one wait condition per step.

The drain waits for four things in turn: the count of in-flight trace words must reach zero, the main FIFO must empty, the resynchronising FIFO must empty, and the outbound valid/ready trace bus must stop holding a beat. After these waits the block pulses a clear to the resynchronising FIFO pointers and enters idle. Once the drain has started it always runs to the end, even if the request goes away. The block also gives a status flag that shows the programming bit as taking effect, and an acknowledge the clock controller uses before it stops the clock on a wait-for-interrupt.

Top module: `trc_quiesce_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, idle is 1, trace_en is 0 and resync_ptr_clr is 0.
- R2: Idle is requested when any of these holds: cfg_pwrdn=1, cfg_prog=1, cfg_enable=0, os_lock=1, wfi_req=1, or both dbg_invasive and dbg_observe are 0. A request seen at a clock edge while running drives trace_en to 0 after that edge.
- R3: After trace is stopped, the drain waits for inflight_cnt==0, then for main_empty=1, then for resync_empty=1, in that order. Until every earlier wait is met, idle stays 0 and no pointer clear is issued.
- R4: The bus step finishes only at an edge where bus_valid=0, or where bus_valid=1 and bus_ready=1. While bus_valid=1 and bus_ready=0, the drain holds.
- R5: resync_ptr_clr is high for exactly one cycle, and idle rises in the next cycle. If every wait condition is already met, idle is 1 seven clock edges after the edge that sees the request, and the clear pulse comes after the sixth.
- R6: Removing a request in the middle of a drain does not stop the drain. The internal programming bit stays set until the drain has finished. As a result, prog_status reads 1 in the first idle cycle even when cfg_prog has already returned to 0.
- R7: prog_status is 1 only when idle is 1 and at least one of the programming bit (the input or its held copy), cfg_pwrdn or os_lock is 1. An idle caused only by enable or debug inputs reads 0.
- R8: wfi_ack is 0 throughout a drain. It is 1 while idle and wfi_req are both 1, and it falls once wfi_req goes low.
- R9: In idle, if no request source is active (and no held programming bit remains), the block leaves idle at the next edge and trace_en becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pwrdn | input | 1 | Power-down configuration bit |
| cfg_prog | input | 1 | Programming configuration bit |
| cfg_enable | input | 1 | Trace enable configuration bit (0 requests idle) |
| os_lock | input | 1 | Save/restore lock |
| wfi_req | input | 1 | Wait-for-interrupt idle request |
| dbg_invasive | input | 1 | Invasive debug enable |
| dbg_observe | input | 1 | Non-invasive debug enable |
| inflight_cnt | input | CNT_W | Number of trace words produced but not yet in the FIFO |
| main_empty | input | 1 | Main FIFO empty flag |
| resync_empty | input | 1 | Resynchronising FIFO empty flag |
| bus_valid | input | 1 | Outbound trace bus valid |
| bus_ready | input | 1 | Outbound trace bus ready |
| trace_en | output | 1 | Trace generation enable |
| resync_ptr_clr | output | 1 | One-cycle clear of resync FIFO pointers |
| idle | output | 1 | Block is in idle |
| prog_status | output | 1 | Programming bit reported as in effect |
| wfi_ack | output | 1 | Clock may be stopped for wait-for-interrupt |

## Verification
Every output decodes the state register directly, so a wrong state shows at the ports in the same cycle. A wait step that is skipped or merged shows up as resync_ptr_clr or idle going high while a blocking flag (inflight count, FIFO empty or bus stall) is still present. This is caught on the first cycle sampled while that flag is held. A drain that is aborted shows up as trace_en returning during the drain. A bad held programming copy shows up as a wrong prog_status in the first idle cycle, or as an idle period of the wrong length.

// File: rtl/trc_quiesce_pkg.sv
package trc_quiesce_pkg;
  typedef enum logic [2:0] {
    QS_RUN        = 3'd0,
    QS_HALT       = 3'd1,
    QS_WAIT_INFL  = 3'd2,
    QS_DRN_MAIN   = 3'd3,
    QS_DRN_RSYNC  = 3'd4,
    QS_DRN_BUS    = 3'd5,
    QS_PTR_ZERO   = 3'd6,
    QS_IDLE       = 3'd7
  } qs_state_e;
endpackage

// File: rtl/trc_quiesce_req.sv
module trc_quiesce_req (
  input  logic clk,
  input  logic rst,
  input  logic cfg_pwrdn,
  input  logic cfg_prog,
  input  logic cfg_enable,
  input  logic os_lock,
  input  logic wfi_req,
  input  logic dbg_invasive,
  input  logic dbg_observe,
  input  logic draining,
  output logic idle_req,
  output logic prog_eff
);
  // Held copy of the programming bit: it survives a withdrawal until the drain ends
  logic prog_hold;

  always_ff @(posedge clk) begin
    if (rst) prog_hold <= 1'b0;
    else     prog_hold <= cfg_prog | (prog_hold & draining);
  end

  always_comb begin
    prog_eff = cfg_prog | prog_hold;
    idle_req = prog_eff | cfg_pwrdn | ~cfg_enable | os_lock | wfi_req
             | (~dbg_invasive & ~dbg_observe);
  end

  assert_prog_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (prog_hold && draining) |=> prog_hold);
endmodule

// File: rtl/trc_quiesce_fsm.sv
module trc_quiesce_fsm
  import trc_quiesce_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_req,
  input  logic [CNT_W-1:0] inflight_cnt,
  input  logic             main_empty,
  input  logic             resync_empty,
  input  logic             bus_valid,
  input  logic             bus_ready,
  output qs_state_e        state,
  output logic             draining
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  qs_state_e state_n;
  logic      bus_done;

  always_comb begin
    bus_done = ~bus_valid | bus_ready;
    state_n  = state;
    unique case (state)
      QS_RUN:       if (idle_req) state_n = QS_HALT;
      QS_HALT:      state_n = QS_WAIT_INFL;
      QS_WAIT_INFL: if (inflight_cnt == CNT_ZERO) state_n = QS_DRN_MAIN;
      QS_DRN_MAIN:  if (main_empty) state_n = QS_DRN_RSYNC;
      QS_DRN_RSYNC: if (resync_empty) state_n = QS_DRN_BUS;
      QS_DRN_BUS:   if (bus_done) state_n = QS_PTR_ZERO;
      QS_PTR_ZERO:  state_n = QS_IDLE;
      QS_IDLE:      if (!idle_req) state_n = QS_RUN;
      default:      state_n = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= QS_IDLE;
    else     state <= state_n;
  end

  assign draining = (state != QS_RUN) && (state != QS_IDLE);

  assert_idle_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (state == QS_IDLE && $past(state) != QS_IDLE) |-> $past(state) == QS_PTR_ZERO);
  assert_clr_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (state == QS_PTR_ZERO) |=> (state == QS_IDLE));
  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state == QS_DRN_BUS && bus_valid && !bus_ready) |=> (state == QS_DRN_BUS));
  assert_main_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state == QS_DRN_MAIN && !main_empty) |=> (state == QS_DRN_MAIN));
  assert_no_abort_R6: assert property (@(posedge clk) disable iff (rst)
    draining |=> (state != QS_RUN));
endmodule

// File: rtl/trc_quiesce_out.sv
module trc_quiesce_out
  import trc_quiesce_pkg::*;
(
  input  qs_state_e state,
  input  logic      prog_eff,
  input  logic      cfg_pwrdn,
  input  logic      os_lock,
  input  logic      wfi_req,
  output logic      trace_en,
  output logic      resync_ptr_clr,
  output logic      idle,
  output logic      prog_status,
  output logic      wfi_ack
);
  always_comb begin
    trace_en       = (state == QS_RUN);
    resync_ptr_clr = (state == QS_PTR_ZERO);
    idle           = (state == QS_IDLE);
    prog_status    = idle & (prog_eff | cfg_pwrdn | os_lock);
    wfi_ack        = idle & wfi_req;
  end
endmodule

// File: rtl/trc_quiesce_ctrl.sv
module trc_quiesce_ctrl
  import trc_quiesce_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_pwrdn,
  input  logic             cfg_prog,
  input  logic             cfg_enable,
  input  logic             os_lock,
  input  logic             wfi_req,
  input  logic             dbg_invasive,
  input  logic             dbg_observe,
  input  logic [CNT_W-1:0] inflight_cnt,
  input  logic             main_empty,
  input  logic             resync_empty,
  input  logic             bus_valid,
  input  logic             bus_ready,
  output logic             trace_en,
  output logic             resync_ptr_clr,
  output logic             idle,
  output logic             prog_status,
  output logic             wfi_ack
);
  logic      idle_req;
  logic      prog_eff;
  logic      draining;
  qs_state_e state;

  trc_quiesce_req u_req (
    .clk          (clk),
    .rst          (rst),
    .cfg_pwrdn    (cfg_pwrdn),
    .cfg_prog     (cfg_prog),
    .cfg_enable   (cfg_enable),
    .os_lock      (os_lock),
    .wfi_req      (wfi_req),
    .dbg_invasive (dbg_invasive),
    .dbg_observe  (dbg_observe),
    .draining     (draining),
    .idle_req     (idle_req),
    .prog_eff     (prog_eff)
  );

  trc_quiesce_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .idle_req     (idle_req),
    .inflight_cnt (inflight_cnt),
    .main_empty   (main_empty),
    .resync_empty (resync_empty),
    .bus_valid    (bus_valid),
    .bus_ready    (bus_ready),
    .state        (state),
    .draining     (draining)
  );

  trc_quiesce_out u_out (
    .state          (state),
    .prog_eff       (prog_eff),
    .cfg_pwrdn      (cfg_pwrdn),
    .os_lock        (os_lock),
    .wfi_req        (wfi_req),
    .trace_en       (trace_en),
    .resync_ptr_clr (resync_ptr_clr),
    .idle           (idle),
    .prog_status    (prog_status),
    .wfi_ack        (wfi_ack)
  );

  assert_stop_R2: assert property (@(posedge clk) disable iff (rst)
    (trace_en && idle_req) |=> !trace_en);
  assert_ack_drain_R8: assert property (@(posedge clk) disable iff (rst)
    draining |-> !wfi_ack);
endmodule

// File: tb/sim_trc_quiesce_ctrl.sv
module sim_trc_quiesce_ctrl;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_pwrdn, cfg_prog, cfg_enable, os_lock, wfi_req, dbg_invasive, dbg_observe;
  logic [CNT_W-1:0] inflight_cnt;
  logic main_empty, resync_empty, bus_valid, bus_ready;
  logic trace_en, resync_ptr_clr, idle, prog_status, wfi_ack;
  int   nchk = 0;
  int   nfail = 0;

  always #2 clk = ~clk;

  trc_quiesce_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .cfg_pwrdn(cfg_pwrdn), .cfg_prog(cfg_prog),
    .cfg_enable(cfg_enable), .os_lock(os_lock), .wfi_req(wfi_req),
    .dbg_invasive(dbg_invasive), .dbg_observe(dbg_observe),
    .inflight_cnt(inflight_cnt), .main_empty(main_empty),
    .resync_empty(resync_empty), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .trace_en(trace_en), .resync_ptr_clr(resync_ptr_clr), .idle(idle),
    .prog_status(prog_status), .wfi_ack(wfi_ack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    cfg_pwrdn = 0; cfg_prog = 0; cfg_enable = 1; os_lock = 0; wfi_req = 0;
    dbg_invasive = 1; dbg_observe = 1; inflight_cnt = '0;
    main_empty = 1; resync_empty = 1; bus_valid = 0; bus_ready = 0;
  endtask

  task automatic to_run();
    quiet();
    for (int i = 0; i < 10 && !trace_en; i++) tick();
    chk("R9 return to run", trace_en, 1);
  endtask

  task automatic run_to_idle(input string tag);
    for (int i = 0; i < 50 && !idle; i++) tick();
    chk(tag, idle, 1);
  endtask

  task automatic hold_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tick();
      chk(tag, {30'd0, idle, resync_ptr_clr}, 0);
    end
  endtask

  task automatic t_reset();
    quiet(); cfg_enable = 0; rst = 1;
    repeat (3) tick();
    chk("R1 idle in reset", idle, 1);
    chk("R1 trace off in reset", trace_en, 0);
    chk("R1 no clear in reset", resync_ptr_clr, 0);
    rst = 0;
    tick();
    chk("R1 idle after reset", idle, 1);
    chk("R1 trace off after reset", trace_en, 0);
  endtask

  task automatic t_exit();
    quiet();
    tick();
    chk("R9 trace_en one edge after clear", trace_en, 1);
    chk("R9 idle low", idle, 0);
  endtask

  task automatic t_sources();
    for (int s = 0; s < 6; s++) begin
      to_run();
      case (s)
        0: cfg_pwrdn = 1;
        1: cfg_prog = 1;
        2: cfg_enable = 0;
        3: os_lock = 1;
        4: wfi_req = 1;
        default: begin dbg_invasive = 0; dbg_observe = 0; end
      endcase
      tick();
      chk($sformatf("R2 source %0d stops trace", s), trace_en, 0);
      run_to_idle($sformatf("R2 source %0d reaches idle", s));
    end
    // one debug input low alone is not a request
    to_run();
    dbg_invasive = 0;
    repeat (3) tick();
    chk("R2 single debug low keeps running", trace_en, 1);
  endtask

  task automatic t_fast();
    to_run();
    cfg_pwrdn = 1;
    for (int i = 1; i <= 5; i++) begin
      tick();
      chk("R5 no early clear", {30'd0, idle, resync_ptr_clr}, 0);
    end
    tick();
    chk("R5 clear pulse after sixth edge", resync_ptr_clr, 1);
    chk("R5 idle low during clear", idle, 0);
    tick();
    chk("R5 idle after seventh edge", idle, 1);
    chk("R5 clear is single cycle", resync_ptr_clr, 0);
  endtask

  task automatic t_order();
    to_run();
    os_lock = 1; inflight_cnt = 3;
    hold_check(6, "R3 held by inflight count");
    main_empty = 0; resync_empty = 0; bus_valid = 1; bus_ready = 0;
    inflight_cnt = '0;
    hold_check(6, "R3 held by main fifo");
    main_empty = 1;
    hold_check(6, "R3 held by resync fifo");
    resync_empty = 1;
    hold_check(6, "R4 held by stalled bus beat");
    bus_ready = 1;
    tick();
    chk("R4 accepted beat ends bus step", resync_ptr_clr, 1);
    bus_valid = 0; bus_ready = 0;
    tick();
    chk("R5 idle after clear", idle, 1);
  endtask

  task automatic t_cancel();
    to_run();
    cfg_prog = 1; main_empty = 0;
    tick();
    cfg_prog = 0;
    repeat (3) tick();
    chk("R6 drain continues after withdrawal", {31'd0, idle}, 0);
    chk("R6 trace stays off", trace_en, 0);
    main_empty = 1;
    run_to_idle("R6 drain completes");
    chk("R6 held programming bit in first idle cycle", prog_status, 1);
    tick();
    chk("R6 one held idle cycle", idle, 1);
    chk("R6 held copy released", prog_status, 0);
    tick();
    chk("R9 run after held copy clears", trace_en, 1);
  endtask

  task automatic t_status();
    to_run();
    cfg_enable = 0;
    run_to_idle("R7 idle via enable");
    chk("R7 enable-only idle reads 0", prog_status, 0);
    cfg_pwrdn = 1; tick();
    chk("R7 power-down reads 1", prog_status, 1);
    cfg_pwrdn = 0; os_lock = 1; tick();
    chk("R7 lock reads 1", prog_status, 1);
    os_lock = 0; dbg_invasive = 0; dbg_observe = 0; tick();
    chk("R7 debug-only idle reads 0", prog_status, 0);
    to_run();
    cfg_prog = 1; main_empty = 0;
    repeat (3) tick();
    chk("R7 not idle reads 0", prog_status, 0);
    main_empty = 1;
    run_to_idle("R7 idle via prog");
    chk("R7 programming bit reads 1", prog_status, 1);
  endtask

  task automatic t_wfi();
    to_run();
    wfi_req = 1; resync_empty = 0;
    repeat (4) tick();
    chk("R8 no ack during drain", wfi_ack, 0);
    resync_empty = 1;
    run_to_idle("R8 idle on wfi");
    chk("R8 ack in idle", wfi_ack, 1);
    tick();
    chk("R8 ack held", wfi_ack, 1);
    wfi_req = 0;
    tick();
    chk("R8 ack drops", wfi_ack, 0);
    chk("R9 run after wfi removed", trace_en, 1);
  endtask

  initial begin
    quiet();
    tick();
    t_reset();
    t_exit();
    t_sources();
    t_fast();
    t_order();
    t_cancel();
    t_status();
    t_wfi();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    #800000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule